// File: doc/BRIEF.md
# RTC Alarm and Interrupt Unit

This block sits next to a BCD timekeeping counter chain. It produces the clock's interrupts. It holds eight alarm compare registers, one for each time field, and an 8-bit interrupt enable mask. It also holds an 8-bit record of interrupt sources that have fired, a standby-interrupt enable, and a command that wipes the alarm registers.

The counter chain supplies three inputs: the eight current BCD time fields, a millisecond tick, and one rollover strobe for each periodic event. On each millisecond tick the block compares every alarm field against the matching time field. Any field can be marked as "don't care".

Software reaches the block through a 5-bit address, 8-bit data register bus. Reads are combinational while the read strobe is high. Writes take effect at the clock edge. Reading the status register acknowledges every pending source.

Top module: `rtcAlarmUnit`

## Requirements
- R1: After reset, every alarm, control, status and standby-enable register reads 0x00, `irqOut` is 0 and `stbyIrqN` is 1.
- R2: Alarm registers sit at offsets 8 to 15. Offset 8+i holds field i, in this order: thousandths, hundredths, seconds, minutes, hours, day of week, day of month, month. Field i arrives on `timeNow[8i+7:8i]`. A written value reads back unchanged at the same offset.
- R3: An alarm field matches when it equals its time field. For any field other than day of week, it also matches when its top two bits are 11. The day-of-week field also matches when it holds exactly 0x0C; other values with the top bits 11 are compared literally. The alarm fires only when all eight fields match.
- R4: Periodic strobe `periodStb[j]` (bit 6 tenths, 5 seconds, 4 minutes, 3 hours, 2 day, 1 week, 0 month) sets status bit j one cycle later, but only when control bit j (offset 17) is 1. Alarm match uses status and control bit 7.
- R5: Reading offset 16 returns the status register and clears all of its bits at that edge, so `irqOut` is low one cycle later.
- R6: The alarm comparison counts only in cycles where `msTick` is high. A matching time without a tick sets nothing.
- R7: Writing 0x01 to offset 22 enables the standby interrupt and writing 0x00 disables it. While it is enabled, an alarm match drives `stbyIrqN` low whatever bit 7 of the control register holds. A status read or a disable releases it to 1.
- R8: Writing 0xFF to offset 19 clears all eight alarm registers. Any other value written there changes nothing.
- R9: A source that fires in the same cycle as a status read is kept in the status register. It is not lost to the clear.
- R10: `irqOut` is the OR of the status bits that are also set in the control register. Clearing a control bit masks an already-set status bit without erasing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 5 | Register offset |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, valid while regRd is high |
| timeNow | input | 64 | Current BCD time, field i in bits 8i+7:8i |
| msTick | input | 1 | Millisecond tick from the counter chain |
| periodStb | input | 7 | Periodic rollover strobes, bit 6 tenths down to bit 0 month |
| irqOut | output | 1 | Active-high interrupt |
| stbyIrqN | output | 1 | Active-low standby alarm interrupt |

## Verification
Register read data is due in the same cycle as the read strobe. The bench drives each read at a falling edge and samples it a quarter period later, before the rising edge that clears status.

Writes, ticks and strobes all land at the next rising edge. `irqOut` and `stbyIrqN` are therefore checked at the falling edge that follows that edge, one cycle after the stimulus.

Expected read values go into a queue as the driver issues each read. A separate monitor pops and compares them in order, so a read that is missing or comes back late shows up as a mismatch.

// File: rtl/rtcAlarmPkg.sv
package rtcAlarmPkg;
  localparam int ADDR_W       = 5;
  localparam int DATA_W       = 8;
  localparam int NUM_FIELDS   = 8;
  localparam int NUM_PERIODIC = 7;
  localparam int STATUS_W     = NUM_PERIODIC + 1;
  localparam int ALARM_BIT    = STATUS_W - 1;
  localparam int DOW_IDX      = 5;
  localparam int ALARM_BASE   = 8;
  localparam int ADDR_STATUS  = 16;
  localparam int ADDR_CTRL    = 17;
  localparam int ADDR_RAMCLR  = 19;
  localparam int ADDR_STBY    = 22;
  localparam logic [DATA_W-1:0] DOW_ANY   = 8'h0C;
  localparam logic [DATA_W-1:0] CLEAR_KEY = 8'hFF;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] alarmWe;
    logic                  ctrlWe;
    logic                  stbyWe;
    logic                  ramClr;
    logic                  statusRd;
  } ctlStrobe_t;
endpackage

// File: rtl/rtcAlarmCtl.sv
module rtcAlarmCtl
  import rtcAlarmPkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWrData,
  output ctlStrobe_t        strb
);
  logic [NUM_FIELDS-1:0] fieldSel;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_sel
      assign fieldSel[gi] = regWr && (regAddr == ADDR_W'(ALARM_BASE + gi));
    end
  endgenerate

  always_comb begin
    strb          = '0;
    strb.alarmWe  = fieldSel;
    strb.ctrlWe   = regWr && (regAddr == ADDR_W'(ADDR_CTRL));
    strb.stbyWe   = regWr && (regAddr == ADDR_W'(ADDR_STBY));
    strb.ramClr   = regWr && (regAddr == ADDR_W'(ADDR_RAMCLR)) && (regWrData == CLEAR_KEY);
    strb.statusRd = regRd && (regAddr == ADDR_W'(ADDR_STATUS));
  end
endmodule

// File: rtl/rtcAlarmDp.sv
module rtcAlarmDp
  import rtcAlarmPkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  ctlStrobe_t                   strb,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [ADDR_W-1:0]            rdAddr,
  input  logic [NUM_FIELDS*DATA_W-1:0] timeNow,
  input  logic                         msTick,
  input  logic [NUM_PERIODIC-1:0]      periodStb,
  output logic [DATA_W-1:0]            rdData,
  output logic                         irqOut,
  output logic                         stbyIrqN
);
  logic [DATA_W-1:0]     alarmReg [NUM_FIELDS];
  logic [STATUS_W-1:0]   ctrlReg;
  logic [STATUS_W-1:0]   statusReg;
  logic                  stbyEn;
  logic                  stbyFlag;
  logic [NUM_FIELDS-1:0] fieldHit;
  logic                  alarmHit;
  logic [STATUS_W-1:0]   setVec;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
      logic anyVal;
      if (gi == DOW_IDX) begin : g_dow
        assign anyVal = (alarmReg[gi] == DOW_ANY);
      end else begin : g_std
        assign anyVal = (alarmReg[gi][DATA_W-1 -: 2] == 2'b11);
      end
      assign fieldHit[gi] = anyVal || (alarmReg[gi] == timeNow[gi*DATA_W +: DATA_W]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                alarmReg[gi] <= '0;
        else if (strb.ramClr)      alarmReg[gi] <= '0;
        else if (strb.alarmWe[gi]) alarmReg[gi] <= wrData;
      end
    end
  endgenerate

  assign alarmHit = msTick && (&fieldHit);
  assign setVec   = {alarmHit, periodStb} & ctrlReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg   <= '0;
      statusReg <= '0;
      stbyEn    <= 1'b0;
      stbyFlag  <= 1'b0;
    end else begin
      if (strb.ctrlWe) ctrlReg <= wrData[STATUS_W-1:0];
      statusReg <= (strb.statusRd ? '0 : statusReg) | setVec;
      if (strb.stbyWe) begin
        stbyEn <= wrData[0];
        if (!wrData[0]) stbyFlag <= 1'b0;
        else stbyFlag <= (stbyFlag && !strb.statusRd) || (alarmHit && stbyEn);
      end else begin
        stbyFlag <= (stbyFlag && !strb.statusRd) || (alarmHit && stbyEn);
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (rdAddr == ADDR_W'(ALARM_BASE + i)) rdData = alarmReg[i];
    if (rdAddr == ADDR_W'(ADDR_STATUS)) rdData = DATA_W'(statusReg);
    if (rdAddr == ADDR_W'(ADDR_CTRL))   rdData = DATA_W'(ctrlReg);
    if (rdAddr == ADDR_W'(ADDR_STBY))   rdData = DATA_W'(stbyEn);
  end

  assign irqOut   = |(statusReg & ctrlReg);
  assign stbyIrqN = ~stbyFlag;

  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.statusRd && !msTick && (periodStb == '0)) |=> (statusReg == '0)); // R5
  AST_NEW_BITS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((statusReg & ~$past(statusReg) & ~$past(ctrlReg)) == '0)); // R4
  AST_RAM_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ramClr |=> (alarmReg[0] == '0 && alarmReg[DOW_IDX] == '0 && alarmReg[NUM_FIELDS-1] == '0)); // R8
  AST_STBY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !stbyEn |-> stbyIrqN); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqOut) |-> $past(msTick || (|periodStb) || strb.ctrlWe)); // R10
  AST_ALARM_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!msTick && !strb.stbyWe && !stbyFlag) |=> !stbyFlag); // R6
endmodule

// File: rtl/rtcAlarmUnit.sv
module rtcAlarmUnit
  import rtcAlarmPkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic                         regWr,
  input  logic                         regRd,
  input  logic [DATA_W-1:0]            regWrData,
  output logic [DATA_W-1:0]            regRdData,
  input  logic [NUM_FIELDS*DATA_W-1:0] timeNow,
  input  logic                         msTick,
  input  logic [NUM_PERIODIC-1:0]      periodStb,
  output logic                         irqOut,
  output logic                         stbyIrqN
);
  ctlStrobe_t strb;

  rtcAlarmCtl u_ctl (
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regRd     (regRd),
    .regWrData (regWrData),
    .strb      (strb)
  );

  rtcAlarmDp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .wrData    (regWrData),
    .rdAddr    (regAddr),
    .timeNow   (timeNow),
    .msTick    (msTick),
    .periodStb (periodStb),
    .rdData    (regRdData),
    .irqOut    (irqOut),
    .stbyIrqN  (stbyIrqN)
  );
endmodule

// File: tb/rtcAlarmUnit_tb.sv
module rtcAlarmUnit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [4:0]  regAddr = '0;
  logic        regWr = 0, regRd = 0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [63:0] timeNow;
  logic        msTick = 0;
  logic [6:0]  periodStb = '0;
  logic        irqOut, stbyIrqN;
  logic [7:0]  tm [8];

  int nChecks = 0, nErrs = 0;
  bit finished = 0;

  typedef struct { logic [7:0] exp; string tag; } expItem_t;
  expItem_t sbq [$];

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) timeNow[i*8 +: 8] = tm[i];

  rtcAlarmUnit u_dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .timeNow(timeNow),
    .msTick(msTick), .periodStb(periodStb), .irqOut(irqOut), .stbyIrqN(stbyIrqN)
  );

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    #5;
    if (regRd) begin
      nChecks++;
      if (sbq.size() == 0) begin
        nErrs++;
        $display("FAIL unexpected read: actual %h expected none", regRdData);
      end else begin
        expItem_t it;
        it = sbq.pop_front();
        if (regRdData !== it.exp) begin
          nErrs++;
          $display("FAIL %s: actual %h expected %h", it.tag, regRdData, it.exp);
        end
      end
    end
  end

  task automatic wrReg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWr = 1;
    @(posedge clk); #1 regWr = 0;
  endtask

  task automatic rdExp(input logic [4:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); regAddr = a; regRd = 1;
    sbq.push_back('{exp: e, tag: tag});
    @(posedge clk); #1 regRd = 0;
  endtask

  task automatic pulse(input logic ms, input logic [6:0] per);
    @(negedge clk); msTick = ms; periodStb = per;
    @(posedge clk); #1 msTick = 0; periodStb = '0;
  endtask

  task automatic pins(input logic eIrq, input logic eStbyN, input string tag);
    @(negedge clk); #5;
    nChecks++;
    if (irqOut !== eIrq || stbyIrqN !== eStbyN) begin
      nErrs++;
      $display("FAIL %s: actual irq=%b stbyN=%b expected irq=%b stbyN=%b",
               tag, irqOut, stbyIrqN, eIrq, eStbyN);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  localparam logic [7:0] AL [8] = '{8'h05, 8'h42, 8'h30, 8'h15, 8'h09, 8'h03, 8'h21, 8'h07};

  initial begin
    for (int i = 0; i < 8; i++) tm[i] = 8'h00;
    tm[5] = 8'h01;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    pins(1'b0, 1'b1, "R1 pins after reset");
    rdExp(5'd16, 8'h00, "R1 status reset");
    rdExp(5'd17, 8'h00, "R1 ctrl reset");
    rdExp(5'd8,  8'h00, "R1 alarm reset");
    rdExp(5'd22, 8'h00, "R1 standby enable reset");

    // R2 alarm register write/readback
    for (int i = 0; i < 8; i++) wrReg(5'(8 + i), AL[i]);
    for (int i = 0; i < 8; i++) rdExp(5'(8 + i), AL[i], "R2 alarm readback");

    // R4 periodic sources, only enabled ones
    wrReg(5'd17, 8'h20);
    pulse(1'b0, 7'h10);
    pins(1'b0, 1'b1, "R4 disabled minute source");
    pulse(1'b0, 7'h20);
    pins(1'b1, 1'b1, "R4 second source fires");
    // R5 read clears
    rdExp(5'd16, 8'h20, "R5 status content");
    pins(1'b0, 1'b1, "R5 irq dropped after read");
    rdExp(5'd16, 8'h00, "R5 status cleared");
    wrReg(5'd17, 8'h01);
    pulse(1'b0, 7'h01);
    rdExp(5'd16, 8'h01, "R4 month source");

    // R3/R6 alarm match
    for (int i = 0; i < 8; i++) tm[i] = AL[i];
    wrReg(5'd17, 8'h80);
    pulse(1'b0, 7'h00);
    pins(1'b0, 1'b1, "R6 no tick no alarm");
    pulse(1'b1, 7'h00);
    pins(1'b1, 1'b1, "R3 full match");
    rdExp(5'd16, 8'h80, "R3 alarm status bit");
    tm[3] = 8'h16;
    pulse(1'b1, 7'h00);
    pins(1'b0, 1'b1, "R3 minute mismatch");
    tm[3] = AL[3];
    wrReg(5'd8, 8'hC5); tm[0] = 8'h07;
    pulse(1'b1, 7'h00);
    rdExp(5'd16, 8'h80, "R3 wildcard field matches");
    wrReg(5'd13, 8'hC0);
    pulse(1'b1, 7'h00);
    rdExp(5'd16, 8'h00, "R3 day-of-week 0xC0 is literal");
    wrReg(5'd13, 8'h0C);
    pulse(1'b1, 7'h00);
    rdExp(5'd16, 8'h80, "R3 day-of-week 0x0C wildcard");

    // R7 standby interrupt
    wrReg(5'd17, 8'h00);
    wrReg(5'd22, 8'h01);
    rdExp(5'd22, 8'h01, "R7 enable readback");
    pulse(1'b1, 7'h00);
    pins(1'b0, 1'b0, "R7 standby asserts without ctrl");
    rdExp(5'd16, 8'h00, "R7 status untouched by standby");
    pins(1'b0, 1'b1, "R7 released by status read");
    pulse(1'b1, 7'h00);
    pins(1'b0, 1'b0, "R7 asserts again");
    wrReg(5'd22, 8'h00);
    pins(1'b0, 1'b1, "R7 released by disable");
    pulse(1'b1, 7'h00);
    pins(1'b0, 1'b1, "R7 disabled stays high");

    // R9 set during read kept
    wrReg(5'd17, 8'h40);
    @(negedge clk); regAddr = 5'd16; regRd = 1; periodStb = 7'h40;
    sbq.push_back('{exp: 8'h00, tag: "R9 read during event"});
    @(posedge clk); #1 regRd = 0; periodStb = '0;
    pins(1'b1, 1'b1, "R9 irq kept");
    // R10 masking
    wrReg(5'd17, 8'h00);
    pins(1'b0, 1'b1, "R10 masked irq");
    rdExp(5'd16, 8'h40, "R10 status retained while masked");

    // R8 RAM reset
    wrReg(5'd19, 8'hFE);
    rdExp(5'd10, 8'h30, "R8 non-key write ignored");
    wrReg(5'd19, 8'hFF);
    for (int i = 0; i < 8; i++) rdExp(5'(8 + i), 8'h00, "R8 alarm wiped");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule